// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves a byte or a 16-bit word over a clocked serial link. Software loads one or two data registers through a small register port. It picks the word length and the clock source, then writes the start bit. The word leaves on `sdo` least significant bit first. In the same shifts, the bits arriving on `sdi` enter the far end of the shift chain. When the last bit has been taken in, the received word sits aligned in the same registers.

The start bit doubles as a busy indicator. It reads 1 from the cycle after it is set until the final bit has been shifted, and this includes any time spent waiting for an external clock to begin. On the cycle it clears, `doneOut` pulses once. The serial clock can come from a fixed divider of the system clock or from the `sckIn` pin. The pin is synchronised inside the block.

Register map on `regAddr`:
- Address 0 is control. Bit 0 is start/busy, bit 1 is wide (16-bit) mode and bit 2 selects the external clock. All other bits read 0.
- Address 1 is the low data byte, bits 7:0 of a word.
- Address 2 is the high data byte, bits 15:8.
- Address 3 reads 0.

Top module: `ssp_top`

## Requirements
- R1: Writing control (address 0) with bit 0 = 1 while idle starts a transfer. A control write with bit 0 = 0 never starts one and never stops one.
- R2: Control bit 0 reads 1 from the edge that accepts the start until the transfer ends. This includes the wait for the first external clock edge.
- R3: Control bit 0 clears by itself on the edge that shifts in the last bit. `doneOut` is high for exactly that one cycle.
- R4: With control bit 1 = 0, a transfer shifts 8 bits. The bits come from the low register only, and the high register keeps its contents.
- R5: With control bit 1 = 1, a transfer shifts 16 bits. `sdo` carries bits 0..7 of the low register and then bits 0..7 of the high register, LSB first.
- R6: `sdi` bits arrive LSB first. After the transfer, the low register holds received bits 7:0. In 16-bit mode, the high register holds received bits 15:8.
- R7: With control bit 2 = 0, `sckOut` idles high. While busy, it toggles every DIV_HALF system cycles. `sdo` changes on its falling edge, and `sdi` is sampled on its rising edge.
- R8: With control bit 2 = 1, `sckIn` is synchronised. No bit is shifted until a falling edge of `sckIn` has been seen. `sdo` changes on falling edges, and `sdi` is sampled on rising edges.
- R9: Control writes that change bits 1 and 2 are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select |
| regWe | input | 1 | Register write strobe |
| regWrData | input | BYTE_W | Register write data |
| regRdData | output | BYTE_W | Register read data, combinational on regAddr |
| sckIn | input | 1 | External serial clock |
| sckOut | output | 1 | Internal serial clock, high when idle |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| doneOut | output | 1 | One-cycle transfer-complete pulse |

## Verification
The hardest case to reach is an external-clock transfer that has been started but has not yet seen a clock edge. In that state the block must report busy while it shifts nothing. The bench starts such a transfer and holds `sckIn` high for twenty cycles. It checks that busy stays set and that no bit has moved, and only then does it drive the clock. A second hard case is a control write during a transfer. The bench flips the mode bit with start = 0 mid-word and confirms that both the readback and the received bit count are unchanged.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic driveOut;  // serial clock falling edge: present next bit
    logic shiftIn;   // serial clock rising edge: shift chain
    logic wide;      // chain both bytes
  } sspStrobeT;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_LOWER = 2'd1;
  localparam logic [1:0] ADDR_UPPER = 2'd2;

endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int DIV_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlWe,
  input  logic      startIn,
  input  logic      wideIn,
  input  logic      extIn,
  input  logic      sckIn,
  output logic      busy,
  output logic      wideMode,
  output logic      extMode,
  output logic      sckOut,
  output logic      done,
  output sspStrobeT stb
);

  localparam int DIV_W   = $clog2(DIV_HALF + 1);
  localparam int CNT_W   = $clog2(2 * BYTE_W + 1);
  localparam int SYNC_W  = SYNC_STAGES + 1;
  localparam logic [DIV_W-1:0] DIV_LAST    = DIV_W'(DIV_HALF - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2 * BYTE_W - 1);

  logic [SYNC_W-1:0] sckSync;
  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic              sckInt;
  logic              armed;

  logic extFall, extRise, tick, intFall, intRise, fallEv, riseEv, lastBit;

  // synchroniser plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckSync <= '1;
    else       sckSync <= {sckSync[SYNC_W-2:0], sckIn};
  end

  always_comb begin
    extFall = sckSync[SYNC_W-1] & ~sckSync[SYNC_W-2];
    extRise = ~sckSync[SYNC_W-1] & sckSync[SYNC_W-2];
    tick    = (divCnt == DIV_LAST);
    intFall = busy & ~extMode & tick & sckInt;
    intRise = busy & ~extMode & tick & ~sckInt;
    fallEv  = extMode ? (busy & extFall) : intFall;
    riseEv  = extMode ? (busy & extRise & armed) : intRise;
    lastBit = (bitCnt == (wideMode ? LAST_WIDE : LAST_NARROW));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      wideMode <= 1'b0;
      extMode  <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      sckInt   <= 1'b1;
      armed    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= riseEv & lastBit;
      if (!busy) begin
        if (ctrlWe) begin
          wideMode <= wideIn;
          extMode  <= extIn;
          if (startIn) begin
            busy   <= 1'b1;
            bitCnt <= '0;
            divCnt <= '0;
            armed  <= 1'b0;
            sckInt <= 1'b1;
          end
        end
      end else begin
        if (!extMode) divCnt <= tick ? '0 : divCnt + 1'b1;
        if (intFall | intRise) sckInt <= ~sckInt;
        if (fallEv) armed <= 1'b1;
        if (riseEv) begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) begin
            busy   <= 1'b0;
            sckInt <= 1'b1;
          end
        end
      end
    end
  end

  assign sckOut       = extMode ? 1'b1 : sckInt;
  assign stb.driveOut = fallEv;
  assign stb.shiftIn  = riseEv;
  assign stb.wide     = wideMode;

endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sspStrobeT         stb,
  input  logic              wrLower,
  input  logic              wrUpper,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              sdi,
  output logic [BYTE_W-1:0] lowerQ,
  output logic [BYTE_W-1:0] upperQ,
  output logic              sdo
);

  logic lowerIn;

  // in wide mode the upper byte feeds the lower one
  assign lowerIn = stb.wide ? upperQ[0] : sdi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowerQ <= '0;
      upperQ <= '0;
      sdo    <= 1'b1;
    end else begin
      if (stb.driveOut) sdo <= lowerQ[0];
      if (stb.shiftIn) begin
        lowerQ <= {lowerIn, lowerQ[BYTE_W-1:1]};
        if (stb.wide) upperQ <= {sdi, upperQ[BYTE_W-1:1]};
      end else begin
        if (wrLower) lowerQ <= wrData;
        if (wrUpper) upperQ <= wrData;
      end
    end
  end

endmodule

// File: rtl/ssp_top.sv
module ssp_top
  import ssp_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWe,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              sckIn,
  output logic              sckOut,
  input  logic              sdi,
  output logic              sdo,
  output logic              doneOut
);

  sspStrobeT         stb;
  logic              busyQ, wideQ, extQ;
  logic [BYTE_W-1:0] lowerQ, upperQ;
  logic              ctrlWe, wrLower, wrUpper;

  assign ctrlWe  = regWe & (regAddr == ADDR_CTRL);
  assign wrLower = regWe & (regAddr == ADDR_LOWER) & ~busyQ;
  assign wrUpper = regWe & (regAddr == ADDR_UPPER) & ~busyQ;

  ssp_ctrl #(.BYTE_W(BYTE_W), .DIV_HALF(DIV_HALF), .SYNC_STAGES(2)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe),
    .startIn(regWrData[0]), .wideIn(regWrData[1]), .extIn(regWrData[2]),
    .sckIn(sckIn), .busy(busyQ), .wideMode(wideQ), .extMode(extQ),
    .sckOut(sckOut), .done(doneOut), .stb(stb)
  );

  ssp_datapath #(.BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrLower(wrLower), .wrUpper(wrUpper),
    .wrData(regWrData), .sdi(sdi), .lowerQ(lowerQ), .upperQ(upperQ), .sdo(sdo)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  regRdData = BYTE_W'({extQ, wideQ, busyQ});
      ADDR_LOWER: regRdData = lowerQ;
      ADDR_UPPER: regRdData = upperQ;
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/ssp_chk.sv
module ssp_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       wideMode,
  input logic       extMode,
  input logic       doneOut,
  input logic       sckOut,
  input logic       regWe,
  input logic [1:0] regAddr,
  input logic       startBit
);

  // R1
  busy_rise_needs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWe && regAddr == 2'd0 && startBit));

  // R3
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (!busy && $past(busy)));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R7
  idle_sck_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sckOut);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(wideMode) && $stable(extMode)));

endmodule

bind ssp_top ssp_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busyQ), .wideMode(wideQ), .extMode(extQ),
  .doneOut(doneOut), .sckOut(sckOut), .regWe(regWe), .regAddr(regAddr),
  .startBit(regWrData[0])
);

// File: tb/ssp_top_tb_top.sv
module ssp_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 2;
  localparam int EXT_HALF   = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWe = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       sckIn = 1'b1;
  logic       sckOut, sdi = 1'b0, sdo, doneOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ssp_top #(.BYTE_W(8), .DIV_HALF(DIV_HALF)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData), .sckIn(sckIn),
    .sckOut(sckOut), .sdi(sdi), .sdo(sdo), .doneOut(doneOut)
  );

  int nChk = 0;
  int nFail = 0;

  typedef struct { logic [15:0] tx; int len; } expT;
  expT expQ[$];

  logic        active = 1'b0;
  logic        extTb = 1'b0;
  logic [15:0] rxWord = '0;
  logic [15:0] gotTx = '0;
  int          bitIdx = 0;
  logic        prevLine = 1'b1;
  logic        prevDone = 1'b0;
  logic        seenEdge = 1'b0;
  int          sckCnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  // monitor: serial slave and scoreboard, sampling a quarter period after the edge
  always begin
    logic line;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    line = extTb ? sckIn : sckOut;
    sckCnt++;
    if (active) begin
      if (line != prevLine) begin
        if (!extTb && seenEdge)
          check(sckCnt == DIV_HALF, "R7", "serial clock half period", sckCnt, DIV_HALF);
        seenEdge = 1'b1;
        sckCnt = 0;
      end
      if (prevLine && !line && bitIdx < 16) sdi = rxWord[bitIdx];
      if (!prevLine && line && bitIdx < 16) begin
        gotTx[bitIdx] = sdo;
        bitIdx++;
      end
    end
    prevLine = line;
    if (prevDone) check(doneOut == 1'b0, "R3", "done longer than one cycle", doneOut, 0);
    if (doneOut) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "done with nothing expected", 1, 0);
      end else begin
        expT e;
        e = expQ.pop_front();
        if (e.len == 8) check(gotTx[7:0] == e.tx[7:0], "R4", "8-bit serial output", gotTx[7:0], e.tx[7:0]);
        else            check(gotTx == e.tx, "R5", "16-bit serial output", gotTx, e.tx);
        check(bitIdx == e.len, e.len == 8 ? "R4" : "R5", "bit count", bitIdx, e.len);
        check(regRdData[0] == 1'b0, "R3", "busy clear with done", regRdData[0], 0);
      end
      active = 1'b0;
    end
    prevDone = doneOut;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regAddr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
    regAddr = 2'd0;
  endtask

  task automatic xfer(input bit wide, input bit ext, input bit poke,
                      input logic [15:0] tx, input logic [15:0] rx);
    logic [7:0] v;
    int n;
    expT e;
    n = wide ? 16 : 8;
    wr(2'd1, tx[7:0]);
    wr(2'd2, wide ? tx[15:8] : 8'hA5);
    wr(2'd0, {5'd0, ext, wide, 1'b0});
    repeat (4) @(negedge clk);
    check(regRdData == {5'd0, ext, wide, 1'b0}, "R1", "start=0 write stays idle",
          regRdData, {5'd0, ext, wide, 1'b0});
    check(sckOut == 1'b1, "R7", "idle serial clock", sckOut, 1);
    e.tx = tx; e.len = n;
    expQ.push_back(e);
    extTb = ext; rxWord = rx; gotTx = '0; bitIdx = 0; seenEdge = 1'b0; sckCnt = 0;
    active = 1'b1;
    wr(2'd0, {5'd0, ext, wide, 1'b1});
    #1 check(regRdData[0] == 1'b1, "R2", "busy after start", regRdData[0], 1);
    if (poke) begin
      wr(2'd0, {5'd0, ext, ~wide, 1'b0});
      #1 check(regRdData == {5'd0, ext, wide, 1'b1}, "R9", "mode write ignored while busy",
               regRdData, {5'd0, ext, wide, 1'b1});
    end
    if (ext) begin
      repeat (20) @(negedge clk);
      check(regRdData[0] == 1'b1, "R2", "busy while waiting for external clock", regRdData[0], 1);
      check(bitIdx == 0 && sdo == 1'b1, "R8", "no shifting before first external edge", bitIdx, 0);
      for (int i = 0; i < n; i++) begin
        @(negedge clk) sckIn = 1'b0;
        repeat (EXT_HALF) @(negedge clk);
        sckIn = 1'b1;
        repeat (EXT_HALF) @(negedge clk);
      end
    end
    while (active) @(negedge clk);
    repeat (2) @(negedge clk);
    rd(2'd1, v);
    check(v == rx[7:0], "R6", "received low byte", v, rx[7:0]);
    rd(2'd2, v);
    if (wide) check(v == rx[15:8], "R6", "received high byte", v, rx[15:8]);
    else      check(v == 8'hA5, "R4", "high byte untouched in 8-bit mode", v, 8'hA5);
    extTb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog expired: actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(2'd0, v);
    check(v == 8'h00, "R2", "control after reset", v, 0);
    check(sckOut == 1'b1 && doneOut == 1'b0, "R7", "outputs after reset", {sckOut, doneOut}, 2'b10);

    // R1: a zero start bit written while idle starts nothing
    wr(2'd0, 8'h00);
    repeat (10) @(negedge clk);
    check(regRdData[0] == 1'b0 && sckOut == 1'b1, "R1", "no transfer from start=0",
          {regRdData[0], sckOut}, 2'b01);

    xfer(1'b0, 1'b0, 1'b0, 16'h003C, 16'h00C5);
    xfer(1'b1, 1'b0, 1'b1, 16'hB1E4, 16'h5A93);
    xfer(1'b0, 1'b0, 1'b1, 16'h0096, 16'h0069);
    xfer(1'b0, 1'b1, 1'b0, 16'h0081, 16'h007E);
    xfer(1'b1, 1'b1, 1'b1, 16'hF00D, 16'h8001);

    check(expQ.size() == 0, "R3", "every transfer signalled done", expQ.size(), 0);
    summary();
    $finish;
  end

endmodule